// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block decides which interrupt a processor core takes next and names the program-memory word the core jumps to. It holds one pending flag per peripheral source. A request pulse sets the flag. A source is eligible when its flag is set, its own enable input is high and the controller's global-enable flag is set. Among the eligible sources, the one with the lowest vector address wins. Source k (counted from zero) owns vector k+1. Vector 0 is kept for the reset request. The reset request cannot be masked and beats every peripheral.

When the block accepts an interrupt, it raises a one-cycle take strobe together with the vector and a one-hot acknowledge of the served source. In the same edge it clears that source's pending flag and drops the global-enable flag, so the handler runs with further interrupts held off. A return-from-interrupt pulse or a software set raises the global enable again. The block does not save or restore the status register, fetch the vector or push a return address. The core or the handler software does that work.

Top module: `irqc_top`

## Requirements
- R1: After the synchronous reset `rst`, `pend_o`, `ack_o` and `vec_o` are all zero, and `take_o` and `glb_en_o` are low.
- R2: A high `irq_i[k]` at a clock edge sets `pend_o[k]` after that edge. The flag stays set until its source is served or software clears it.
- R3: A high `pend_clr_i[k]` clears `pend_o[k]` at the next edge. If `irq_i[k]` is high in the same cycle, the request wins and the flag stays set.
- R4: A peripheral source is taken only if three things hold at the deciding edge: its pending flag is set, its `irq_en_i` bit is high and `glb_en_o` is high. Otherwise it produces no take and stays pending.
- R5: Among eligible sources the lowest index wins. `vec_o` then equals the index plus one, and `ack_o` has only that source's bit set.
- R6: A source becomes pending at one edge and is taken at the next edge if it is eligible then. When taken, `take_o` is high for exactly one cycle and the served flag is cleared. Sources that lost arbitration stay pending.
- R7: A high `rst_req_i` at an edge gives `take_o` high after that edge, with `vec_o` = 0 and `ack_o` = 0. This holds whatever the enables are. It leaves the pending flags unchanged and beats any eligible peripheral.
- R8: A take of any kind clears `glb_en_o`. Otherwise `reti_i` or `glb_set_i` sets it, and failing those `glb_clr_i` clears it. A take beats set, and set beats clear.
- R9: While `take_o` is low, `vec_o` and `ack_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Request pulse per peripheral source |
| irq_en_i | input | N_SRC | Individual enable per source |
| pend_clr_i | input | N_SRC | Software clear of pending flags |
| rst_req_i | input | 1 | Unmaskable reset request (vector 0) |
| glb_set_i | input | 1 | Software set of the global enable |
| glb_clr_i | input | 1 | Software clear of the global enable |
| reti_i | input | 1 | Return-from-interrupt pulse, sets the global enable |
| take_o | output | 1 | One-cycle strobe: an interrupt is taken |
| vec_o | output | ADDR_W | Vector address of the taken interrupt |
| ack_o | output | N_SRC | One-hot acknowledge of the served source |
| pend_o | output | N_SRC | Pending flags |
| glb_en_o | output | 1 | Global interrupt-enable flag |

## Verification
The assertions assume no particular ordering of the inputs. They do rely on two things. First, `rst` is applied before any checked cycle. Second, the core treats `take_o` as the only point where it enters a handler, so the drop of the global enable always lines up with a take. The stimulus drives every input on the falling clock edge and holds it steady across the next rising edge. It leaves pulse inputs low unless a step is testing that pulse. Where a test needs clean overlap cases, such as a software clear together with a request, or set together with clear, it drives them in the same cycle on purpose. Otherwise the stimulus keeps request, clear and enable changes in separate cycles so that each expected value is unambiguous.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_DEF  = 10;
    localparam int ADDR_DEF = 12;

    // Command applied to the global-enable flag in one cycle.
    typedef enum logic [1:0] {
        GATE_HOLD  = 2'd0,
        GATE_OPEN  = 2'd1,
        GATE_SHUT  = 2'd2,
        GATE_TAKEN = 2'd3
    } gate_cmd_e;

    // Priority order: a take overrides a set, and a set overrides a clear.
    function automatic gate_cmd_e gate_cmd(input logic take, input logic open,
                                           input logic shut);
        if (take)      return GATE_TAKEN;
        else if (open) return GATE_OPEN;
        else if (shut) return GATE_SHUT;
        else           return GATE_HOLD;
    endfunction

    function automatic logic gate_next(input gate_cmd_e cmd, input logic cur);
        case (cmd)
            GATE_OPEN:              return 1'b1;
            GATE_SHUT, GATE_TAKEN:  return 1'b0;
            default:                return cur;
        endcase
    endfunction

endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int N = irqc_pkg::SRC_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] sw_clr_i,
    input  logic [N-1:0] hw_clr_i,
    output logic [N-1:0] pend_o
);
    // One flag per source; a new request outranks any clear in the same cycle.
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[k] <= 1'b0;
            else if (set_i[k])
                pend_o[k] <= 1'b1;
            else if (sw_clr_i[k] || hw_clr_i[k])
                pend_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int N  = irqc_pkg::SRC_DEF,
    parameter int AW = irqc_pkg::ADDR_DEF
) (
    input  logic          rst_req_i,
    input  logic [N-1:0]  elig_i,
    output logic          hit_o,
    output logic [AW-1:0] vec_o,
    output logic [N-1:0]  sel_o
);
    localparam int IDX_W = $clog2(N + 1);

    logic [N:0]   blocked;
    logic [N-1:0] win;

    assign blocked[0] = 1'b0;

    // Lower index blocks every higher index.
    for (genvar k = 0; k < N; k++) begin : g_chain
        assign win[k]         = elig_i[k] & ~blocked[k];
        assign blocked[k + 1] = blocked[k] | elig_i[k];
    end

    logic [AW-1:0] win_vec;

    always_comb begin
        win_vec = '0;
        for (int k = 0; k < N; k++)
            if (win[k]) win_vec = AW'(k + 1);
    end

    // Reset request owns vector zero and suppresses every peripheral grant.
    always_comb begin
        if (rst_req_i) begin
            hit_o = 1'b1;
            vec_o = '0;
            sel_o = '0;
        end else begin
            hit_o = |elig_i;
            vec_o = win_vec;
            sel_o = win;
        end
    end

    initial begin
        if (AW < IDX_W) $error("irqc_arb: ADDR_W too narrow for N_SRC");
    end
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate (
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic open_i,
    input  logic shut_i,
    output logic en_o
);
    import irqc_pkg::*;

    gate_cmd_e cmd;

    assign cmd = gate_cmd(take_i, open_i, shut_i);

    always_ff @(posedge clk) begin
        if (rst) en_o <= 1'b0;
        else     en_o <= gate_next(cmd, en_o);
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int N_SRC  = irqc_pkg::SRC_DEF,
    parameter int ADDR_W = irqc_pkg::ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic [N_SRC-1:0]  irq_en_i,
    input  logic [N_SRC-1:0]  pend_clr_i,
    input  logic              rst_req_i,
    input  logic              glb_set_i,
    input  logic              glb_clr_i,
    input  logic              reti_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [N_SRC-1:0]  ack_o,
    output logic [N_SRC-1:0]  pend_o,
    output logic              glb_en_o
);
    logic [N_SRC-1:0]  pend_q;
    logic [N_SRC-1:0]  elig;
    logic [N_SRC-1:0]  sel;
    logic [ADDR_W-1:0] vec_n;
    logic              hit;
    logic              gen_q;

    irqc_pend #(.N(N_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_i    (irq_i),
        .sw_clr_i (pend_clr_i),
        .hw_clr_i (sel),
        .pend_o   (pend_q)
    );

    assign elig = pend_q & irq_en_i & {N_SRC{gen_q}};

    irqc_arb #(.N(N_SRC), .AW(ADDR_W)) u_arb (
        .rst_req_i (rst_req_i),
        .elig_i    (elig),
        .hit_o     (hit),
        .vec_o     (vec_n),
        .sel_o     (sel)
    );

    irqc_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .take_i (hit),
        .open_i (glb_set_i | reti_i),
        .shut_i (glb_clr_i),
        .en_o   (gen_q)
    );

    // Registered grant: strobe, vector and acknowledge change on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            take_o <= 1'b0;
            vec_o  <= '0;
            ack_o  <= '0;
        end else begin
            take_o <= hit;
            vec_o  <= hit ? vec_n : '0;
            ack_o  <= sel;
        end
    end

    assign pend_o   = pend_q;
    assign glb_en_o = gen_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int N  = irqc_pkg::SRC_DEF,
    parameter int AW = irqc_pkg::ADDR_DEF
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  irq_i,
    input logic [N-1:0]  pend_clr_i,
    input logic          take_o,
    input logic [AW-1:0] vec_o,
    input logic [N-1:0]  ack_o,
    input logic [N-1:0]  pend_o,
    input logic          glb_en_o
);
    logic [AW-1:0] ack_vec;

    always_comb begin
        ack_vec = '0;
        for (int k = 0; k < N; k++)
            if (ack_o[k]) ack_vec = AW'(k + 1);
    end

    // R5: at most one source acknowledged
    a_r5_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o));

    // R5: vector agrees with the acknowledged source
    a_r5_vec_matches_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_o != '0) |-> (vec_o == ack_vec && take_o));

    // R8: a take leaves the global enable cleared
    a_r8_take_clears_gie: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !glb_en_o);

    // R4: a peripheral take needs the global enable one cycle earlier
    a_r4_needs_gie: assert property (@(posedge clk) disable iff (rst)
        (ack_o != '0) |-> $past(glb_en_o));

    // R7: a take without an acknowledge is the reset vector
    a_r7_reset_vec: assert property (@(posedge clk) disable iff (rst)
        (take_o && ack_o == '0) |-> vec_o == '0);

    // R9: idle outputs are zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vec_o == '0 && ack_o == '0));

    // R6: a served source's flag is cleared unless re-requested
    for (genvar k = 0; k < N; k++) begin : g_bit
        a_r6_served_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_o[k] && !$past(irq_i[k])) |-> !pend_o[k]);

        // R2: a set flag holds unless served or cleared
        a_r2_pend_holds: assert property (@(posedge clk) disable iff (rst)
            ($past(pend_o[k]) && !$past(pend_clr_i[k]) && !ack_o[k]) |-> pend_o[k]);
    end
endmodule

bind irqc_top irqc_chk #(.N(N_SRC), .AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_i      (irq_i),
    .pend_clr_i (pend_clr_i),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .ack_o      (ack_o),
    .pend_o     (pend_o),
    .glb_en_o   (glb_en_o)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int N  = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_i, irq_en_i, pend_clr_i;
    logic          rst_req_i, glb_set_i, glb_clr_i, reti_i;
    logic          take_o, glb_en_o;
    logic [AW-1:0] vec_o;
    logic [N-1:0]  ack_o, pend_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqc_top #(.N_SRC(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .irq_i(irq_i), .irq_en_i(irq_en_i),
        .pend_clr_i(pend_clr_i), .rst_req_i(rst_req_i), .glb_set_i(glb_set_i),
        .glb_clr_i(glb_clr_i), .reti_i(reti_i), .take_o(take_o), .vec_o(vec_o),
        .ack_o(ack_o), .pend_o(pend_o), .glb_en_o(glb_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        irq_i = '0; pend_clr_i = '0; rst_req_i = 1'b0;
        glb_set_i = 1'b0; glb_clr_i = 1'b0; reti_i = 1'b0;
    endtask

    function automatic logic [N-1:0] bit_of(input int k);
        return N'(1) << k;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        quiet();
        irq_en_i = '0;
        rst = 1'b1;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 take", 32'(take_o), 0);
        chk("R1 glb", 32'(glb_en_o), 0);
        chk("R1 vec", 32'(vec_o), 0);
        chk("R1 ack", 32'(ack_o), 0);

        // R2 R5 R6 single source sweep
        irq_en_i = '1;
        for (int k = 0; k < N; k++) begin
            irq_i = bit_of(k); glb_set_i = 1'b1;
            step(); quiet();
            chk("R2 latched", 32'(pend_o), 32'(bit_of(k)));
            chk("R6 not yet", 32'(take_o), 0);
            step();
            chk("R6 take", 32'(take_o), 1);
            chk("R5 vec", 32'(vec_o), 32'(k + 1));
            chk("R5 ack", 32'(ack_o), 32'(bit_of(k)));
            chk("R6 served", 32'(pend_o), 0);
            chk("R8 closed", 32'(glb_en_o), 0);
            step();
            chk("R9 idle vec", 32'(vec_o), 0);
            chk("R6 strobe", 32'(take_o), 0);
        end

        // R5 R6 pair priority sweep
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                irq_i = bit_of(i) | bit_of(j); glb_set_i = 1'b1;
                step(); quiet();
                step();
                chk("R5 pair win", 32'(vec_o), 32'(i + 1));
                chk("R6 loser pending", 32'(pend_o), 32'(bit_of(j)));
                reti_i = 1'b1;
                step(); quiet();
                chk("R8 reti opens", 32'(glb_en_o), 1);
                step();
                chk("R5 second", 32'(vec_o), 32'(j + 1));
                step();
            end
        end

        // R4 individual mask sweep
        for (int k = 0; k < N; k++) begin
            irq_en_i = ~bit_of(k);
            irq_i = bit_of(k); glb_set_i = 1'b1;
            step(); quiet();
            step();
            chk("R4 masked no take", 32'(take_o), 0);
            chk("R4 masked pending", 32'(pend_o), 32'(bit_of(k)));
            irq_en_i = '1;
            step();
            chk("R4 unmasked take", 32'(vec_o), 32'(k + 1));
            step();
        end

        // R4 global enable low
        irq_i = bit_of(2);
        step(); quiet();
        step();
        chk("R4 gie low", 32'(take_o), 0);
        chk("R4 gie low pend", 32'(pend_o), 32'(bit_of(2)));
        reti_i = 1'b1;
        step(); quiet();
        chk("R8 reti", 32'(take_o), 0);
        step();
        chk("R4 gie high take", 32'(vec_o), 3);
        step();

        // R7 reset request beats peripheral, ignores enables
        irq_i = bit_of(3); glb_set_i = 1'b1;
        step(); quiet();
        rst_req_i = 1'b1;
        step(); quiet();
        chk("R7 take", 32'(take_o), 1);
        chk("R7 vec", 32'(vec_o), 0);
        chk("R7 ack", 32'(ack_o), 0);
        chk("R7 pend kept", 32'(pend_o), 32'(bit_of(3)));
        chk("R8 reset closes", 32'(glb_en_o), 0);
        step();
        irq_en_i = '0; rst_req_i = 1'b1;
        step(); quiet();
        chk("R7 unmaskable", 32'(take_o), 1);
        irq_en_i = '1; reti_i = 1'b1;
        step(); quiet();
        step();
        chk("R7 after", 32'(vec_o), 4);
        step();

        // R3 software clear and its overlap with a request
        irq_i = bit_of(5);
        step(); quiet();
        pend_clr_i = bit_of(5);
        step(); quiet();
        chk("R3 cleared", 32'(pend_o), 0);
        irq_i = bit_of(6);
        step(); quiet();
        irq_i = bit_of(6); pend_clr_i = bit_of(6);
        step(); quiet();
        chk("R3 request wins", 32'(pend_o), 32'(bit_of(6)));
        pend_clr_i = bit_of(6);
        step(); quiet();

        // R8 set versus clear precedence
        glb_set_i = 1'b1; glb_clr_i = 1'b1;
        step(); quiet();
        chk("R8 set beats clr", 32'(glb_en_o), 1);
        glb_clr_i = 1'b1;
        step(); quiet();
        chk("R8 clr", 32'(glb_en_o), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule